// File: doc/BRIEF.md
# Core Thread Partition Controller

This block keeps the partition mode of an eight-thread processor core. A core runs either as one whole core, as two subcores of four threads, or as four subcores of two threads. Software writes a small control word that holds a disable bit for dynamic unsplitting and two split-request bits, one for two-way and one for four-way. Each thread also sends in a nap signal.

From the current mode the block drives a status bit for each split mode, the subcore count, a subcore index for every thread and a sibling mask for every thread. Split requests are honoured only from the unsplit mode. The core falls back to unsplit by itself once every thread except thread 0 is napping, provided the disable bit is clear. Every mode change lands two clock edges after the event that caused it.

Top module: `core_partition_ctrl`

## Requirements
- R1: After reset the core is unsplit, the disable bit is clear, both split status bits are clear, the subcore count is 1 and every sibling mask is 8'hFF.
- R2: A write (ctl_we high) with ctl_wdata[1]=1 and ctl_wdata[2]=0 while unsplit enters two-way mode. One with ctl_wdata[2]=1 and ctl_wdata[1]=0 enters four-way mode. The new mode appears on the outputs after the second rising edge that follows the cycle in which the write was presented.
- R3: A write with both ctl_wdata[1] and ctl_wdata[2] set is illegal and leaves the mode unchanged.
- R4: A request for one split mode while the core is in the other split mode is ignored. The core never passes directly between two-way and four-way.
- R5: When the effective disable bit is clear and nap[7:1] are all high while the core is split, the core returns to unsplit after the second following rising edge. The state of nap[0] has no effect.
- R6: While the disable bit (ctl_wdata[0], held in a register) is set, no automatic unsplit happens. A write presented in the same cycle as the nap condition takes effect for that cycle's decision.
- R7: The subcore index of thread t is 0 when unsplit, t/4 in two-way mode and t/2 in four-way mode. The index is two bits per thread at thread_subcore[2t+1:2t].
- R8: The sibling mask of thread t is (2^k − 1) shifted left by the first thread of its subcore, where k is the number of threads per subcore (8, 4 or 2). The mask is eight bits per thread at sibling_mask[8t+7:8t].
- R9: sub_count reads 1, 2 or 4. two_way is high only in two-way mode and four_way only in four-way mode, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | [0] unsplit disable, [1] request two-way, [2] request four-way |
| nap | input | 8 | Per-thread nap indication, bit t for thread t |
| unsplit_dis | output | 1 | Stored disable bit |
| two_way | output | 1 | Core is in two-way mode |
| four_way | output | 1 | Core is in four-way mode |
| sub_count | output | 3 | Number of subcores: 1, 2 or 4 |
| thread_subcore | output | 16 | Two-bit subcore index per thread |
| sibling_mask | output | 64 | Eight-bit sibling mask per thread |

## Verification
A control write and the automatic unsplit condition can land in the same cycle. The bench provokes this by setting all nap bits of threads 1 to 7 in the same cycle as a write. In one case the write sets the disable bit, and the core must stay split. In another case the write clears the bit, and the core must unsplit. A third case writes both request bits while the naps are present, and the write must change nothing. Each case is judged two edges later at the mode outputs and in the per-thread index and mask fields.

// File: rtl/core_partition_ctrl.sv
module core_partition_ctrl #(
  parameter int THREADS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_we,
  input  logic [2:0]                   ctl_wdata,
  input  logic [THREADS-1:0]           nap,
  output logic                         unsplit_dis,
  output logic                         two_way,
  output logic                         four_way,
  output logic [2:0]                   sub_count,
  output logic [2*THREADS-1:0]         thread_subcore,
  output logic [THREADS*THREADS-1:0]   sibling_mask
);

  localparam logic [1:0] M_ONE  = 2'd0;
  localparam logic [1:0] M_TWO  = 2'd1;
  localparam logic [1:0] M_FOUR = 2'd2;
  localparam int T2 = THREADS / 2;
  localparam int T4 = THREADS / 4;
  localparam logic [THREADS-1:0] ALL = '1;

  logic [1:0] mode_q, pend_q;
  logic       pend_v, dis_q;

  wire       dis_eff   = ctl_we ? ctl_wdata[0] : dis_q;
  wire [1:0] mode_eff  = pend_v ? pend_q : mode_q;
  wire       want_two  = ctl_we & ctl_wdata[1] & ~ctl_wdata[2];
  wire       want_four = ctl_we & ctl_wdata[2] & ~ctl_wdata[1];
  wire       idle_rest = &nap[THREADS-1:1];
  wire       auto_un   = (mode_eff != M_ONE) & idle_rest & ~dis_eff;
  wire       split_go  = (mode_eff == M_ONE) & (want_two | want_four);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_ONE;
      pend_q <= M_ONE;
      pend_v <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      if (ctl_we) dis_q <= ctl_wdata[0];
      pend_v <= split_go | auto_un;
      if (split_go)     pend_q <= want_four ? M_FOUR : M_TWO;
      else if (auto_un) pend_q <= M_ONE;
      if (pend_v) mode_q <= pend_q;
    end
  end

  assign unsplit_dis = dis_q;
  assign two_way     = (mode_q == M_TWO);
  assign four_way    = (mode_q == M_FOUR);
  assign sub_count   = four_way ? 3'd4 : two_way ? 3'd2 : 3'd1;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    localparam int I2 = t / T2;
    localparam int I4 = t / T4;
    localparam logic [THREADS-1:0] MK2 = (ALL >> (THREADS - T2)) << (I2 * T2);
    localparam logic [THREADS-1:0] MK4 = (ALL >> (THREADS - T4)) << (I4 * T4);
    assign thread_subcore[2*t +: 2] = two_way ? 2'(I2) : four_way ? 2'(I4) : 2'd0;
    assign sibling_mask[THREADS*t +: THREADS] = two_way ? MK2 : four_way ? MK4 : ALL;
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (sub_count == 3'd1 && !two_way && !four_way && !unsplit_dis &&
                sibling_mask == {THREADS*THREADS{1'b1}}));

  p_split_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (split_go && want_two) |-> ##2 two_way);

  p_both_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2:1] == 2'b11 && mode_q == M_ONE && !pend_v) |-> ##2 (sub_count == 3'd1));

  p_no_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (two_way |=> !four_way) and (four_way |=> !two_way));

  p_auto_un_r5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_un |-> ##2 (sub_count == 3'd1));

  p_dis_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sub_count) != 3'd1 && sub_count == 3'd1) |-> $past(!dis_eff, 2));

  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({two_way, four_way}) &&
    (sub_count == 3'd1 || sub_count == 3'd2 || sub_count == 3'd4));

endmodule

// File: tb/test_core_partition_ctrl.sv
module test_core_partition_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = 3'b000;
  logic [7:0]  nap = 8'h00;
  logic        unsplit_dis, two_way, four_way;
  logic [2:0]  sub_count;
  logic [15:0] thread_subcore;
  logic [63:0] sibling_mask;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  core_partition_ctrl i_core_partition_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .nap(nap),
    .unsplit_dis(unsplit_dis), .two_way(two_way), .four_way(four_way),
    .sub_count(sub_count), .thread_subcore(thread_subcore), .sibling_mask(sibling_mask)
  );

  // {we, wdata[2:0], nap[7:0], expected subcore count}
  localparam logic [14:0] VEC [11] = '{
    {1'b1, 3'b010, 8'h00, 3'd2},  // R2 enter two-way
    {1'b1, 3'b100, 8'h00, 3'd2},  // R4 four-way request from two-way ignored
    {1'b0, 3'b000, 8'hFE, 3'd1},  // R5 auto unsplit
    {1'b1, 3'b101, 8'h00, 3'd4},  // R2 enter four-way, disable set
    {1'b0, 3'b000, 8'hFE, 3'd4},  // R6 disable blocks unsplit
    {1'b1, 3'b000, 8'hFE, 3'd1},  // R6 same-cycle clear lets unsplit happen
    {1'b1, 3'b110, 8'hFE, 3'd1},  // R3 both requests illegal
    {1'b1, 3'b011, 8'h00, 3'd2},  // R2 two-way with disable
    {1'b1, 3'b000, 8'h7E, 3'd2},  // R5 thread 7 awake, no unsplit
    {1'b0, 3'b000, 8'hFF, 3'd1},  // R5 nap[0] irrelevant
    {1'b1, 3'b001, 8'h00, 3'd1}   // R2 disable-only write does not split
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_layout(input int cnt);
    int k;
    k = 8 / cnt;
    chk("R9 sub_count", int'(sub_count), cnt);
    chk("R9 two_way", int'(two_way), int'(cnt == 2));
    chk("R9 four_way", int'(four_way), int'(cnt == 4));
    for (int t = 0; t < 8; t++) begin
      int idx;
      int msk;
      idx = t / k;
      msk = ((1 << k) - 1) << (idx * k);
      chk("R7 subcore index", int'(thread_subcore[2*t +: 2]), idx);
      chk("R8 sibling mask", int'(sibling_mask[8*t +: 8]), msk & 8'hFF);
    end
  endtask

  task automatic apply(input logic we, input logic [2:0] wd, input logic [7:0] nv);
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; nap = nv;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  initial begin
    #4ms;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 disable bit", int'(unsplit_dis), 0);
    chk("R1 full mask", int'(sibling_mask == 64'hFFFF_FFFF_FFFF_FFFF), 1);
    check_layout(1);

    for (int v = 0; v < 11; v++) begin
      apply(VEC[v][14], VEC[v][13:11], VEC[v][10:3]);
      @(negedge clk);
      chk($sformatf("vector %0d mode", v), int'(sub_count), int'(VEC[v][2:0]));
      check_layout(int'(VEC[v][2:0]));
    end

    // R6 same-cycle: naps line up while the write sets the disable bit
    apply(1'b1, 3'b010, 8'h00);
    @(negedge clk);
    chk("R2 two-way entered", int'(sub_count), 2);
    apply(1'b1, 3'b001, 8'hFE);
    @(negedge clk);
    chk("R6 same-cycle disable keeps split", int'(sub_count), 2);
    chk("R6 disable stored", int'(unsplit_dis), 1);
    repeat (3) @(negedge clk);
    chk("R6 still split", int'(sub_count), 2);

    // back to unsplit, then R2 latency on four-way entry
    apply(1'b1, 3'b000, 8'hFE);
    @(negedge clk);
    chk("R5 unsplit", int'(sub_count), 1);
    @(negedge clk);
    nap = 8'h00;
    ctl_we = 1'b1; ctl_wdata = 3'b100;
    @(negedge clk);
    ctl_we = 1'b0;
    chk("R2 no change after one edge", int'(sub_count), 1);
    @(negedge clk);
    chk("R2 four-way after two edges", int'(sub_count), 4);
    check_layout(4);

    // R4 two-way request in four-way ignored
    apply(1'b1, 3'b010, 8'h00);
    repeat (2) @(negedge clk);
    chk("R4 stays four-way", int'(sub_count), 4);

    // R1 reset from split mode
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset unsplit", int'(sub_count), 1);
    chk("R1 reset disable", int'(unsplit_dis), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_layout(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule